// File: doc/BRIEF.md
# Five-Stage In-Order Integer Pipeline

This block is a small in-order processor core built as a five-stage pipeline: instruction fetch, decode, execute, memory access and write-back. Four latch banks split the stages. On every clock edge each stage takes its inputs from the bank in front of it and writes its results into the bank behind it, so every instruction in flight moves forward together. It runs four operations: add, nand, word load and word store. These work on eight 32-bit registers. The instruction store and the data store are word arrays inside the core.

There is no interlock, no forwarding between stages, no stall and no flush. Software must keep dependent instructions far enough apart. The register file passes a value being written back straight to a decode read of the same register in that same cycle, so a consumer placed three slots after its producer sees the new value. The execute stage also forms a branch target (next PC plus offset) and an equality flag, but no logic uses them yet. Both arrays are filled through a load port while reset is held. After the program has drained, the state is read through two combinational inspection ports: one for a register and one for a data word.

Top module: `pipe5_core`

## Requirements
- R1: While reset is low, the PC is 0, all four latch banks hold a nop and registers 1 to 7 read zero. After release, an all-nop program leaves every register and every data word unchanged.
- R2: Fetch reads one instruction per cycle from word `PC[9:2]` and advances the PC by 4. Instructions take effect in address order.
- R3: Add has opcode bits[6:0]=0110011, bits[14:12]=000 and bits[31:25]=0000000. Its destination index is in bits[11:7], its first source in bits[19:15] and its second source in bits[24:20]. It writes the 32-bit wrapped sum of the two sources.
- R4: Nand has opcode 0110011, bits[14:12]=111 and bits[31:25]=0100000. It writes the bitwise inverse of the AND of the two sources.
- R5: Word load has opcode 0000011 and bits[14:12]=010. Its byte address is the first source plus the sign-extended bits[31:20]. It reads data word address[9:2], ignoring the low two address bits.
- R6: Word store has opcode 0100011 and bits[14:12]=010. Its offset is bits[31:25] placed above bits[11:7], sign-extended. It writes the second source register to data word (first source + offset)[9:2].
- R7: Any other encoding, including the all-zero word, the all-ones word and the listed opcodes with other bits[14:12] or bits[31:25] values, changes no register and no data word.
- R8: Register 0 always reads zero and writes to it are dropped. Only bits[2:0] of each register index field are used, so index 9 selects register 1.
- R9: A consumer three slots after its producer reads the produced value through the same-cycle bypass. A consumer two slots after its producer reads the old value, because the core has no interlock.
- R10: After reset release, the instruction at word k writes its register at clock edge k+5, and a store at word k writes the data array at clock edge k+4. Both count from the first edge with reset high.
- R11: Writes on the load port take effect only while reset is low. While the core runs they change neither array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset; the load port works only while it is low |
| prog_we | input | 1 | Load-port write strobe |
| prog_dmem | input | 1 | Load-port target: 1 selects the data array, 0 the instruction array |
| prog_addr | input | 8 | Load-port word index |
| prog_wdata | input | 32 | Load-port write data |
| peek_reg_idx | input | 3 | Register number to inspect |
| peek_reg_data | output | 32 | Stored value of the inspected register (no bypass) |
| peek_mem_addr | input | 8 | Data word index to inspect |
| peek_mem_data | output | 32 | Stored value of the inspected data word |

## Verification
A latch that drops or duplicates an instruction, or a control bit that goes to the wrong stage, appears at the inspection ports as a register or data word holding the wrong value. A store shows up on the data word at edge k+4 and a register write shows up at edge k+5, so each check is made on the exact edge where the new value should first be stored. Spacing errors, such as a wrong bypass or an interlock that should not be there, show up as a two-slot consumer reading the new value or a three-slot consumer reading the old one. Mis-decoding shows up as a register or word changed by an encoding that must be inert, or as a store that lands on the wrong word because its split offset was joined wrongly.

// File: rtl/pipe5_pkg.sv
`timescale 1ns/1ps
package pipe5_pkg;

    localparam int XLEN   = 32;
    localparam int NREG   = 8;
    localparam int RIDX_W = $clog2(NREG);

    typedef logic [XLEN-1:0]   word_t;
    typedef logic [RIDX_W-1:0] ridx_t;

    localparam logic [6:0] OPC_ALU   = 7'b0110011;
    localparam logic [6:0] OPC_LOAD  = 7'b0000011;
    localparam logic [6:0] OPC_STORE = 7'b0100011;
    localparam logic [2:0] F3_ADD    = 3'b000;
    localparam logic [2:0] F3_NAND   = 3'b111;
    localparam logic [2:0] F3_WORD   = 3'b010;
    localparam logic [6:0] F7_ADD    = 7'b0000000;
    localparam logic [6:0] F7_NAND   = 7'b0100000;

    typedef struct packed {
        logic reg_we;
        logic mem_rd;
        logic mem_wr;
        logic use_imm;
        logic do_nand;
    } ctrl_t;

    localparam ctrl_t CTRL_NOP = '0;

    typedef struct packed {
        word_t inst;
        word_t pc4;
    } ifid_t;

    typedef struct packed {
        ctrl_t ctrl;
        ridx_t rd;
        word_t a;
        word_t b;
        word_t imm;
        word_t pc4;
    } idex_t;

    typedef struct packed {
        ctrl_t ctrl;
        ridx_t rd;
        word_t alu;
        word_t sdata;
    } exmem_t;

    typedef struct packed {
        ctrl_t ctrl;
        ridx_t rd;
        word_t ldata;
        word_t alu;
    } memwb_t;

    typedef struct packed {
        word_t  pc;
        ifid_t  ifid;
        idex_t  idex;
        exmem_t exmem;
        memwb_t memwb;
    } core_state_t;

    // All-zero state: PC 0, instruction word 0 (inert), every control bit clear.
    localparam core_state_t ST_RESET = '0;

endpackage

// File: rtl/pipe5_decode.sv
`timescale 1ns/1ps
module pipe5_decode
    import pipe5_pkg::*;
(
    input  word_t inst,
    output ctrl_t ctrl,
    output ridx_t rd,
    output ridx_t rs1,
    output ridx_t rs2,
    output word_t imm
);

    logic [6:0] opc;
    logic [2:0] f3;
    logic [6:0] f7;
    logic       unused_idx_hi;

    assign opc = inst[6:0];
    assign f3  = inst[14:12];
    assign f7  = inst[31:25];

    // Index fields: only the low bits address the eight registers.
    assign rd  = inst[7 +: RIDX_W];
    assign rs1 = inst[15 +: RIDX_W];
    assign rs2 = inst[20 +: RIDX_W];
    assign unused_idx_hi = ^inst[19:15+RIDX_W];

    always_comb begin
        ctrl = CTRL_NOP;
        imm  = '0;
        unique case (opc)
            OPC_ALU: begin
                if (f3 == F3_ADD && f7 == F7_ADD) begin
                    ctrl.reg_we = 1'b1;
                end else if (f3 == F3_NAND && f7 == F7_NAND) begin
                    ctrl.reg_we  = 1'b1;
                    ctrl.do_nand = 1'b1;
                end
            end
            OPC_LOAD: begin
                if (f3 == F3_WORD) begin
                    ctrl.reg_we  = 1'b1;
                    ctrl.mem_rd  = 1'b1;
                    ctrl.use_imm = 1'b1;
                end
                imm = {{(XLEN-12){inst[31]}}, inst[31:20]};
            end
            OPC_STORE: begin
                if (f3 == F3_WORD) begin
                    ctrl.mem_wr  = 1'b1;
                    ctrl.use_imm = 1'b1;
                end
                imm = {{(XLEN-12){inst[31]}}, inst[31:25], inst[11:7]};
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pipe5_regfile.sv
`timescale 1ns/1ps
module pipe5_regfile
    import pipe5_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  we,
    input  ridx_t wa,
    input  word_t wd,
    input  ridx_t ra_a,
    output word_t rd_a,
    input  ridx_t ra_b,
    output word_t rd_b,
    input  ridx_t pa,
    output word_t pd
);

    word_t regs_q [NREG];
    word_t regs_d [NREG];

    always_comb begin
        regs_d = regs_q;
        if (we && wa != '0) begin
            regs_d[wa] = wd;
        end
        regs_d[0] = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                regs_q[i] <= '0;
            end
        end else begin
            regs_q <= regs_d;
        end
    end

    // Decode reads see a write-back to the same register in the same cycle.
    function automatic word_t read_port(input ridx_t ra, input logic w_en,
                                        input ridx_t w_a, input word_t w_d,
                                        input word_t stored);
        if (ra == '0)                return '0;
        else if (w_en && w_a == ra)  return w_d;
        else                         return stored;
    endfunction

    assign rd_a = read_port(ra_a, we, wa, wd, regs_q[ra_a]);
    assign rd_b = read_port(ra_b, we, wa, wd, regs_q[ra_b]);
    assign pd   = regs_q[pa];

    // R8: register 0 reads as zero on both decode ports
    assert_x0_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_a == '0) |-> (rd_a == '0 && (ra_b != '0 || rd_b == '0)));

    // R10: a write-back to a non-zero register is stored at the next edge
    assert_writeback_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wa != '0) |=> (regs_q[$past(wa)] == $past(wd)));

endmodule

// File: rtl/pipe5_ram.sv
`timescale 1ns/1ps
module pipe5_ram
    import pipe5_pkg::*;
#(
    parameter int WORDS = 256,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  word_t         wdata,
    input  logic [AW-1:0] raddr0,
    output word_t         rdata0,
    input  logic [AW-1:0] raddr1,
    output word_t         rdata1
);

    word_t mem_q [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata0 = mem_q[raddr0];
    assign rdata1 = mem_q[raddr1];

endmodule

// File: rtl/pipe5_core.sv
`timescale 1ns/1ps
module pipe5_core
    import pipe5_pkg::*;
#(
    parameter int MEM_WORDS = 256,
    localparam int AW       = $clog2(MEM_WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prog_we,
    input  logic          prog_dmem,
    input  logic [AW-1:0] prog_addr,
    input  logic [31:0]   prog_wdata,
    input  logic [2:0]    peek_reg_idx,
    output logic [31:0]   peek_reg_data,
    input  logic [AW-1:0] peek_mem_addr,
    output logic [31:0]   peek_mem_data
);

    core_state_t st_q, st_d;

    word_t pc_plus4;
    word_t imem_word;
    word_t imem_spare;

    ctrl_t dec_ctrl;
    ridx_t dec_rd, dec_rs1, dec_rs2;
    word_t dec_imm;
    word_t rf_a, rf_b;

    word_t ex_opb, ex_alu, ex_target;
    logic  ex_eq;

    logic          dm_we;
    logic [AW-1:0] dm_waddr;
    word_t         dm_wdata;
    word_t         dm_rdata;

    word_t wb_value;
    logic  unused_top;

    // ---------------- fetch ----------------
    assign pc_plus4 = st_q.pc + 32'd4;

    pipe5_ram #(.WORDS(MEM_WORDS)) i_imem (
        .clk    (clk),
        .we     (prog_we && !prog_dmem && !rst_n),
        .waddr  (prog_addr),
        .wdata  (prog_wdata),
        .raddr0 (st_q.pc[AW+1:2]),
        .rdata0 (imem_word),
        .raddr1 ('0),
        .rdata1 (imem_spare)
    );

    // ---------------- decode ----------------
    pipe5_decode i_decode (
        .inst (st_q.ifid.inst),
        .ctrl (dec_ctrl),
        .rd   (dec_rd),
        .rs1  (dec_rs1),
        .rs2  (dec_rs2),
        .imm  (dec_imm)
    );

    assign wb_value = st_q.memwb.ctrl.mem_rd ? st_q.memwb.ldata : st_q.memwb.alu;

    pipe5_regfile i_regfile (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (st_q.memwb.ctrl.reg_we),
        .wa   (st_q.memwb.rd),
        .wd   (wb_value),
        .ra_a (dec_rs1),
        .rd_a (rf_a),
        .ra_b (dec_rs2),
        .rd_b (rf_b),
        .pa   (peek_reg_idx),
        .pd   (peek_reg_data)
    );

    // ---------------- execute ----------------
    assign ex_opb    = st_q.idex.ctrl.use_imm ? st_q.idex.imm : st_q.idex.b;
    assign ex_alu    = st_q.idex.ctrl.do_nand ? ~(st_q.idex.a & ex_opb)
                                              : (st_q.idex.a + ex_opb);
    assign ex_target = st_q.idex.pc4 + st_q.idex.imm;
    assign ex_eq     = (st_q.idex.a == st_q.idex.b);

    // ---------------- memory ----------------
    always_comb begin
        if (rst_n) begin
            dm_we    = st_q.exmem.ctrl.mem_wr;
            dm_waddr = st_q.exmem.alu[AW+1:2];
            dm_wdata = st_q.exmem.sdata;
        end else begin
            dm_we    = prog_we && prog_dmem;
            dm_waddr = prog_addr;
            dm_wdata = prog_wdata;
        end
    end

    pipe5_ram #(.WORDS(MEM_WORDS)) i_dmem (
        .clk    (clk),
        .we     (dm_we),
        .waddr  (dm_waddr),
        .wdata  (dm_wdata),
        .raddr0 (st_q.exmem.alu[AW+1:2]),
        .rdata0 (dm_rdata),
        .raddr1 (peek_mem_addr),
        .rdata1 (peek_mem_data)
    );

    // ---------------- next state ----------------
    always_comb begin
        st_d = st_q;

        st_d.pc   = pc_plus4;
        st_d.ifid = '{inst: imem_word, pc4: pc_plus4};

        st_d.idex = '{ctrl: dec_ctrl, rd: dec_rd, a: rf_a, b: rf_b,
                      imm: dec_imm, pc4: st_q.ifid.pc4};

        st_d.exmem = '{ctrl: st_q.idex.ctrl, rd: st_q.idex.rd,
                       alu: ex_alu, sdata: st_q.idex.b};

        st_d.memwb = '{ctrl: st_q.exmem.ctrl, rd: st_q.exmem.rd,
                       ldata: dm_rdata, alu: st_q.exmem.alu};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RESET;
        else        st_q <= st_d;
    end

    // Branch target and compare are formed but not yet consumed.
    assign unused_top = ^{st_q.pc[1:0], st_q.pc[XLEN-1:AW+2],
                          st_q.exmem.alu[1:0], st_q.exmem.alu[XLEN-1:AW+2],
                          imem_spare, ex_target, ex_eq};

    // R2: the PC steps by one word every running cycle
    assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (st_q.pc == $past(st_q.pc) + 32'd4));

    // R6: a store in the memory stage was a store in execute one edge earlier
    assert_store_lockstep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.exmem.ctrl.mem_wr |-> $past(st_q.idex.ctrl.mem_wr));

    // R6: a store never also claims a register write
    assert_store_no_regwrite_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.idex.ctrl.mem_wr |-> !st_q.idex.ctrl.reg_we);

    // R11: while running, data writes come only from a store in the memory stage
    assert_prog_blocked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        dm_we |-> st_q.exmem.ctrl.mem_wr);

endmodule

// File: tb/test_pipe5_core.sv
`timescale 1ns/1ps
module test_pipe5_core;
    import pipe5_pkg::*;

    localparam int MEMW = 256;
    localparam int AWB  = $clog2(MEMW);
    localparam int PLEN = 32;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           prog_we = 1'b0;
    logic           prog_dmem = 1'b0;
    logic [AWB-1:0] prog_addr = '0;
    logic [31:0]    prog_wdata = '0;
    logic [2:0]     peek_reg_idx = '0;
    logic [31:0]    peek_reg_data;
    logic [AWB-1:0] peek_mem_addr = '0;
    logic [31:0]    peek_mem_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    word_t pbuf [PLEN];

    always #2 clk = ~clk;

    pipe5_core #(.MEM_WORDS(MEMW)) i_pipe5_core (
        .clk(clk), .rst_n(rst_n),
        .prog_we(prog_we), .prog_dmem(prog_dmem),
        .prog_addr(prog_addr), .prog_wdata(prog_wdata),
        .peek_reg_idx(peek_reg_idx), .peek_reg_data(peek_reg_data),
        .peek_mem_addr(peek_mem_addr), .peek_mem_data(peek_mem_data)
    );

    typedef struct packed {
        logic  nand_op;
        word_t a;
        word_t b;
        word_t exp;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b0, 32'h0000_0005, 32'h0000_0007, 32'h0000_000C},
        '{1'b0, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000},
        '{1'b0, 32'h8000_0000, 32'h8000_0000, 32'h0000_0000},
        '{1'b0, 32'h1234_0000, 32'h0000_5678, 32'h1234_5678},
        '{1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000},
        '{1'b1, 32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF},
        '{1'b1, 32'hF0F0_F0F0, 32'hFF00_FF00, 32'h0FFF_0FFF},
        '{1'b1, 32'hAAAA_AAAA, 32'h5555_5555, 32'hFFFF_FFFF}
    };

    // ---------------- encoders (field layout from R3..R6) ----------------
    function automatic word_t enc_alu(input logic is_nand, input logic [4:0] rd,
                                      input logic [4:0] rs1, input logic [4:0] rs2);
        return {is_nand ? 7'b0100000 : 7'b0000000, rs2, rs1,
                is_nand ? 3'b111 : 3'b000, rd, 7'b0110011};
    endfunction

    function automatic word_t enc_lw(input logic [4:0] rd, input logic [4:0] rs1,
                                     input logic [11:0] imm);
        return {imm, rs1, 3'b010, rd, 7'b0000011};
    endfunction

    function automatic word_t enc_sw(input logic [4:0] rs2, input logic [4:0] rs1,
                                     input logic [11:0] imm);
        return {imm[11:5], rs2, rs1, 3'b010, imm[4:0], 7'b0100011};
    endfunction

    // ---------------- helpers ----------------
    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input word_t got, input word_t exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic load_word(input logic to_dmem, input int addr, input word_t val);
        @(negedge clk);
        prog_we    = 1'b1;
        prog_dmem  = to_dmem;
        prog_addr  = addr[AWB-1:0];
        prog_wdata = val;
        @(negedge clk);
        prog_we    = 1'b0;
    endtask

    task automatic reg_val(input int idx, output word_t v);
        peek_reg_idx = idx[2:0];
        #0.1;
        v = peek_reg_data;
    endtask

    task automatic mem_val(input int addr, output word_t v);
        peek_mem_addr = addr[AWB-1:0];
        #0.1;
        v = peek_mem_data;
    endtask

    task automatic enter_reset();
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < PLEN; i++) pbuf[i] = 32'h0;
    endtask

    task automatic load_prog();
        for (int i = 0; i < PLEN; i++) load_word(1'b0, i, pbuf[i]);
    endtask

    task automatic release_reset();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // ---------------- main ----------------
    initial begin
        word_t v;

        // Clear both arrays while reset is held.
        for (int i = 0; i < MEMW; i++) load_word(1'b0, i, 32'h0);
        for (int i = 0; i < MEMW; i++) load_word(1'b1, i, 32'h0);

        // R2 R3 R4 R6: vector table, one program per entry
        for (int n = 0; n < 8; n++) begin
            enter_reset();
            pbuf[0] = enc_lw(5'd1, 5'd0, 12'd0);
            pbuf[1] = enc_lw(5'd2, 5'd0, 12'd4);
            pbuf[4] = enc_alu(VECS[n].nand_op, 5'd3, 5'd1, 5'd2);
            pbuf[7] = enc_sw(5'd3, 5'd0, 12'd8);
            load_prog();
            load_word(1'b1, 0, VECS[n].a);
            load_word(1'b1, 1, VECS[n].b);
            load_word(1'b1, 2, 32'h0);
            release_reset();
            tick(20);
            reg_val(3, v);
            chk(VECS[n].nand_op ? "R4 nand result (R2 order)" : "R3 add result (R2 order)",
                v, VECS[n].exp);
            mem_val(2, v);
            chk("R6 stored result", v, VECS[n].exp);
        end

        // R1: reset clears registers, then an all-nop program changes nothing
        enter_reset();
        for (int r = 1; r < 8; r++) begin
            reg_val(r, v);
            chk("R1 register zero in reset", v, 32'h0);
        end
        load_prog();
        load_word(1'b1, 0, 32'h0000_1234);
        release_reset();
        tick(10);
        reg_val(3, v);
        chk("R1 nop program leaves register", v, 32'h0);
        mem_val(0, v);
        chk("R1 nop program leaves memory", v, 32'h0000_1234);

        // R10: exact write edges; store at word 0 (edge 4), load at word 1 (edge 6)
        enter_reset();
        pbuf[0] = enc_sw(5'd0, 5'd0, 12'd20);
        pbuf[1] = enc_lw(5'd1, 5'd0, 12'd0);
        load_prog();
        load_word(1'b1, 0, 32'h0000_0055);
        load_word(1'b1, 5, 32'h0000_0077);
        release_reset();
        tick(3);
        mem_val(5, v);
        chk("R10 store not yet at edge 3", v, 32'h0000_0077);
        tick(1);
        mem_val(5, v);
        chk("R10 store lands at edge 4", v, 32'h0);
        tick(1);
        reg_val(1, v);
        chk("R10 load not yet at edge 5", v, 32'h0);
        tick(1);
        reg_val(1, v);
        chk("R10 load lands at edge 6", v, 32'h0000_0055);

        // R11: load-port write while running is dropped
        load_word(1'b1, 9, 32'h0000_0BAD);
        tick(2);
        mem_val(9, v);
        chk("R11 running load-port write ignored", v, 32'h0);

        // R9: distance 2 sees old value, distance 3 sees bypassed value
        enter_reset();
        pbuf[0] = enc_lw(5'd1, 5'd0, 12'd0);
        pbuf[2] = enc_alu(1'b0, 5'd2, 5'd1, 5'd1);
        pbuf[3] = enc_alu(1'b0, 5'd3, 5'd1, 5'd1);
        load_prog();
        load_word(1'b1, 0, 32'd5);
        release_reset();
        tick(15);
        reg_val(2, v);
        chk("R9 two-slot consumer reads old value", v, 32'h0);
        reg_val(3, v);
        chk("R9 three-slot consumer reads bypassed value", v, 32'd10);

        // R5 R6: offsets, low address bits, negative offset, split store offset
        enter_reset();
        pbuf[0] = enc_lw(5'd1, 5'd0, 12'd0);
        pbuf[1] = enc_lw(5'd6, 5'd0, 12'd6);
        pbuf[3] = enc_lw(5'd7, 5'd1, 12'hFF8);
        pbuf[4] = enc_sw(5'd6, 5'd0, 12'd44);
        pbuf[6] = enc_sw(5'd7, 5'd1, 12'd47);
        load_prog();
        load_word(1'b1, 0, 32'd16);
        load_word(1'b1, 1, 32'h0000_00A1);
        load_word(1'b1, 2, 32'h0000_00B2);
        load_word(1'b1, 11, 32'h0);
        load_word(1'b1, 15, 32'h0);
        release_reset();
        tick(20);
        reg_val(6, v);
        chk("R5 low address bits ignored", v, 32'h0000_00A1);
        reg_val(7, v);
        chk("R5 negative offset from base", v, 32'h0000_00B2);
        mem_val(11, v);
        chk("R6 split offset store", v, 32'h0000_00A1);
        mem_val(15, v);
        chk("R6 base plus offset, low bits ignored", v, 32'h0000_00B2);

        // R7: inert encodings
        enter_reset();
        pbuf[0] = enc_lw(5'd1, 5'd0, 12'd0);
        pbuf[3] = {7'b0000000, 5'd1, 5'd1, 3'b001, 5'd5, 7'b0110011};
        pbuf[4] = 32'hFFFF_FFFF;
        pbuf[5] = {7'b0100000, 5'd1, 5'd1, 3'b000, 5'd6, 7'b0110011};
        pbuf[6] = {7'b0000000, 5'd1, 5'd0, 3'b000, 5'd12, 7'b0100011};
        pbuf[7] = {12'd0, 5'd0, 3'b000, 5'd7, 7'b0000011};
        load_prog();
        load_word(1'b1, 0, 32'd7);
        load_word(1'b1, 3, 32'h0000_DEAD);
        release_reset();
        tick(20);
        reg_val(5, v);
        chk("R7 other ALU function writes nothing", v, 32'h0);
        reg_val(6, v);
        chk("R7 other funct7 writes nothing", v, 32'h0);
        reg_val(7, v);
        chk("R7 all-ones and other load width write nothing", v, 32'h0);
        mem_val(3, v);
        chk("R7 other store width writes no memory", v, 32'h0000_DEAD);

        // R8: register 0 and index aliasing
        enter_reset();
        pbuf[0] = enc_lw(5'd1, 5'd0, 12'd0);
        pbuf[1] = enc_lw(5'd2, 5'd0, 12'd4);
        pbuf[4] = enc_alu(1'b0, 5'd0, 5'd1, 5'd2);
        pbuf[5] = enc_alu(1'b0, 5'd13, 5'd9, 5'd10);
        pbuf[8] = enc_alu(1'b0, 5'd4, 5'd0, 5'd0);
        load_prog();
        load_word(1'b1, 0, 32'd3);
        load_word(1'b1, 1, 32'd4);
        release_reset();
        tick(20);
        reg_val(0, v);
        chk("R8 register 0 reads zero", v, 32'h0);
        reg_val(4, v);
        chk("R8 write to register 0 dropped", v, 32'h0);
        reg_val(5, v);
        chk("R8 index low bits only", v, 32'd7);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule